// File: doc/BRIEF.md
# Line-Crossing Load Splitter

This block sits beside a load port and handles loads whose byte range runs past the end of a 64-byte cache line. Each dispatch carries an address, a byte count and an operation tag. Once the address is known, the block compares the line offset plus the size against the line length. A load that fits in one line reads its line and completes in the next cycle.

A load that crosses a line needs two dispatches. On the first, the block reads the lower line, stores the bytes that belong to the load in one of a small pool of holding slots, and tells the scheduler to dispatch the same operation again. On the second, the block recognises the tag, reads the following line, joins the two parts and completes. If a crossing load arrives while every slot is taken, it is refused and a saturating stall counter goes up by one.

The cache port is a plain combinational line read: the block presents a line address and takes the whole line back in the same cycle. Cache misses are handled outside the block.

Top module: `split_load_unit`

## Requirements
- R1: While reset is high, and in the cycle after it, `rsp_valid` is 0 and `stall_count` is 0. After reset no holding slot is occupied, so two crossing loads can each be parked.
- R2: A dispatch with offset (address bits [5:0]) plus size at or below 64 reads line `req_addr[31:6]`. One cycle later it answers with kind 2'b00 (complete). Result byte i is memory byte address+i for i below size; the bytes above size are zero (little-endian).
- R3: A dispatch with offset plus size above 64 whose tag is not parked, made while a slot is free, reads line `req_addr[31:6]`. One cycle later it answers with kind 2'b01 (dispatch again) and all-zero data.
- R4: A crossing dispatch whose tag is parked reads line `req_addr[31:6]+1`. It completes with kind 2'b00. The low 64-offset bytes of the result come from the first line and the rest from the start of the next line, little-endian.
- R5: Completing the second dispatch frees its slot, so a later crossing load can be parked.
- R6: There are two slots. A crossing dispatch whose tag is not parked, made while both slots are full, answers with kind 2'b10 (refused) and zero data, and adds one to `stall_count`. The parked data stays intact.
- R7: `stall_count` holds at its maximum, 65535, and does not wrap.
- R8: Every dispatch gets exactly one response, one cycle later, with `rsp_tag` equal to the dispatched tag. A cycle without a dispatch gives `rsp_valid` 0 one cycle later.
- R9: `req_size` is the byte count, from 1 to 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Dispatch present this cycle |
| req_addr | input | 32 | Byte address of the load |
| req_size | input | 6 | Byte count, 1 to 32 |
| req_tag | input | 4 | Operation tag |
| cache_rd_line | output | 26 | Line address read this cycle |
| cache_rd_data | input | 512 | Line contents for `cache_rd_line`, byte 0 in bits [7:0] |
| rsp_valid | output | 1 | Response present |
| rsp_kind | output | 2 | 00 complete, 01 dispatch again, 10 refused |
| rsp_tag | output | 4 | Tag of the answered dispatch |
| rsp_data | output | 256 | Load result, little-endian, zero above the size |
| stall_count | output | 16 | Saturating count of refused dispatches |

## Verification
The properties assume that sizes stay between 1 and 32. They also assume that a crossing load is dispatched again with the same address, size and tag, and that two live loads never share a tag. Under these assumptions every tag match is a genuine second dispatch. The stimulus picks a fresh tag for each load and re-dispatches only with the values of the first dispatch. Random addresses are pushed towards line ends so that crossing and non-crossing loads both occur. Separate directed sequences fill the pool, refuse a load and drive the counter into saturation.

// File: rtl/slu_pkg.sv
package slu_pkg;
  typedef enum logic [1:0] {
    RSP_DONE    = 2'b00,
    RSP_REPLAY  = 2'b01,
    RSP_BLOCKED = 2'b10
  } slu_rsp_e;
endpackage

// File: rtl/slu_span_check.sv
module slu_span_check #(
  parameter int LINE_BYTES = 64,
  parameter int OFF_W      = 6,
  parameter int SIZE_W     = 6
) (
  input  logic [OFF_W-1:0]  off,
  input  logic [SIZE_W-1:0] size,
  output logic              crosses,
  output logic [SIZE_W-1:0] low_cnt,
  output logic [SIZE_W-1:0] high_cnt
);
  int span_end;

  always_comb begin
    span_end = int'(off) + int'(size);
    crosses  = span_end > LINE_BYTES;
    if (crosses) begin
      low_cnt  = SIZE_W'(LINE_BYTES - int'(off));
      high_cnt = SIZE_W'(span_end - LINE_BYTES);
    end else begin
      low_cnt  = size;
      high_cnt = '0;
    end
  end
endmodule

// File: rtl/slu_byte_pick.sv
module slu_byte_pick #(
  parameter int LINE_BYTES = 64,
  parameter int MAX_BYTES  = 32,
  parameter int OFF_W      = 6,
  parameter int SIZE_W     = 6,
  localparam int LINE_W    = LINE_BYTES * 8,
  localparam int DATA_W    = MAX_BYTES * 8
) (
  input  logic [LINE_W-1:0] line,
  input  logic [OFF_W-1:0]  src,
  input  logic [SIZE_W-1:0] dst,
  input  logic [SIZE_W-1:0] cnt,
  output logic [DATA_W-1:0] out
);
  function automatic logic [7:0] byte_at(input logic [LINE_W-1:0] l, input int idx);
    return l[idx*8 +: 8];
  endfunction

  always_comb begin
    out = '0;
    for (int i = 0; i < MAX_BYTES; i++) begin
      if (i >= int'(dst) && i < int'(dst) + int'(cnt) &&
          int'(src) + i - int'(dst) < LINE_BYTES)
        out[i*8 +: 8] = byte_at(line, int'(src) + i - int'(dst));
    end
  end
endmodule

// File: rtl/slu_hold_pool.sv
module slu_hold_pool #(
  parameter int NUM_BUF = 2,
  parameter int TAG_W   = 4,
  parameter int DATA_W  = 256,
  localparam int IW     = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TAG_W-1:0]  lk_tag,
  input  logic              alloc_en,
  input  logic [DATA_W-1:0] alloc_data,
  input  logic              rel_en,
  output logic              hit,
  output logic [DATA_W-1:0] hit_data,
  output logic              free_any
);
  logic [DATA_W-1:0] slot_mem [NUM_BUF];
  logic [TAG_W-1:0]  slot_tag [NUM_BUF];
  logic [NUM_BUF-1:0] slot_vld;
  logic [IW-1:0] hit_idx, free_idx;

  always_comb begin
    hit = 1'b0; hit_idx = '0; free_any = 1'b0; free_idx = '0;
    for (int b = NUM_BUF - 1; b >= 0; b--) begin
      if (slot_vld[b] && slot_tag[b] == lk_tag) begin
        hit = 1'b1; hit_idx = IW'(b);
      end
      if (!slot_vld[b]) begin
        free_any = 1'b1; free_idx = IW'(b);
      end
    end
    hit_data = hit ? slot_mem[hit_idx] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_vld <= '0;
    end else begin
      if (alloc_en) begin
        slot_vld[free_idx] <= 1'b1;
        slot_tag[free_idx] <= lk_tag;
      end
      if (rel_en) slot_vld[hit_idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_en) slot_mem[free_idx] <= alloc_data;
  end
endmodule

// File: rtl/split_load_unit.sv
module split_load_unit
  import slu_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int MAX_BYTES  = 32,
  parameter int TAG_W      = 4,
  parameter int NUM_BUF    = 2,
  parameter int CNT_W      = 16,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int SIZE_W    = $clog2(MAX_BYTES + 1),
  localparam int LINE_AW   = ADDR_W - OFF_W,
  localparam int LINE_W    = LINE_BYTES * 8,
  localparam int DATA_W    = MAX_BYTES * 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [SIZE_W-1:0]  req_size,
  input  logic [TAG_W-1:0]   req_tag,
  output logic [LINE_AW-1:0] cache_rd_line,
  input  logic [LINE_W-1:0]  cache_rd_data,
  output logic               rsp_valid,
  output logic [1:0]         rsp_kind,
  output logic [TAG_W-1:0]   rsp_tag,
  output logic [DATA_W-1:0]  rsp_data,
  output logic [CNT_W-1:0]   stall_count
);
  logic [OFF_W-1:0]  off;
  logic [LINE_AW-1:0] line_a;
  logic              crosses, hit, free_any, second;
  logic [SIZE_W-1:0] low_cnt, high_cnt;
  logic [OFF_W-1:0]  pick_src;
  logic [SIZE_W-1:0] pick_dst, pick_cnt;
  logic [DATA_W-1:0] picked, hit_data, data_d;
  logic              alloc_en, rel_en, stall_inc;
  slu_rsp_e          kind_d;

  assign off    = req_addr[OFF_W-1:0];
  assign line_a = req_addr[ADDR_W-1:OFF_W];

  slu_span_check #(.LINE_BYTES(LINE_BYTES), .OFF_W(OFF_W), .SIZE_W(SIZE_W)) u_span (
    .off(off), .size(req_size), .crosses(crosses), .low_cnt(low_cnt), .high_cnt(high_cnt)
  );

  slu_hold_pool #(.NUM_BUF(NUM_BUF), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_pool (
    .clk(clk), .rst(rst), .lk_tag(req_tag), .alloc_en(alloc_en), .alloc_data(picked),
    .rel_en(rel_en), .hit(hit), .hit_data(hit_data), .free_any(free_any)
  );

  assign second        = crosses && hit;
  assign cache_rd_line = second ? line_a + LINE_AW'(1) : line_a;
  assign pick_src      = second ? '0 : off;
  assign pick_dst      = second ? low_cnt : '0;
  assign pick_cnt      = second ? high_cnt : low_cnt;

  slu_byte_pick #(.LINE_BYTES(LINE_BYTES), .MAX_BYTES(MAX_BYTES), .OFF_W(OFF_W),
                  .SIZE_W(SIZE_W)) u_pick (
    .line(cache_rd_data), .src(pick_src), .dst(pick_dst), .cnt(pick_cnt), .out(picked)
  );

  always_comb begin
    kind_d = RSP_DONE; data_d = '0;
    alloc_en = 1'b0; rel_en = 1'b0; stall_inc = 1'b0;
    if (!crosses) begin
      data_d = picked;
    end else if (hit) begin
      data_d = picked | hit_data;
      rel_en = req_valid;
    end else if (free_any) begin
      kind_d   = RSP_REPLAY;
      alloc_en = req_valid;
    end else begin
      kind_d    = RSP_BLOCKED;
      stall_inc = req_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_kind    <= RSP_DONE;
      rsp_tag     <= '0;
      rsp_data    <= '0;
      stall_count <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_kind  <= kind_d;
      rsp_tag   <= req_tag;
      rsp_data  <= req_valid ? data_d : '0;
      if (stall_inc && stall_count != '1) stall_count <= stall_count + CNT_W'(1);
    end
  end
endmodule

// File: rtl/split_load_unit_checker.sv
module split_load_unit_checker #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int MAX_BYTES  = 32,
  parameter int TAG_W      = 4,
  parameter int CNT_W      = 16,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int SIZE_W    = $clog2(MAX_BYTES + 1),
  localparam int LINE_AW   = ADDR_W - OFF_W,
  localparam int DATA_W    = MAX_BYTES * 8
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic [ADDR_W-1:0]  req_addr,
  input logic [SIZE_W-1:0]  req_size,
  input logic [TAG_W-1:0]   req_tag,
  input logic [LINE_AW-1:0] cache_rd_line,
  input logic               rsp_valid,
  input logic [1:0]         rsp_kind,
  input logic [TAG_W-1:0]   rsp_tag,
  input logic [DATA_W-1:0]  rsp_data,
  input logic [CNT_W-1:0]   stall_count
);
  logic fits;
  assign fits = int'(req_addr[OFF_W-1:0]) + int'(req_size) <= LINE_BYTES;

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!rsp_valid && stall_count == '0));

  a_r8_one_response: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  a_r8_idle_silent: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  a_r8_tag_echo: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_tag == $past(req_tag));

  a_r2_own_line: assert property (@(posedge clk) disable iff (rst)
    (req_valid && fits) |-> cache_rd_line == req_addr[ADDR_W-1:OFF_W]);

  a_r2_fit_completes: assert property (@(posedge clk) disable iff (rst)
    (req_valid && fits) |=> rsp_kind == 2'b00);

  a_r3_no_data_unless_done: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_kind != 2'b00) |-> rsp_data == '0);

  a_r6_count_steps_on_refusal: assert property (@(posedge clk) disable iff (rst)
    (stall_count != $past(stall_count)) |->
      (stall_count == $past(stall_count) + CNT_W'(1) && rsp_valid && rsp_kind == 2'b10));
endmodule

bind split_load_unit split_load_unit_checker #(
  .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .MAX_BYTES(MAX_BYTES),
  .TAG_W(TAG_W), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/split_load_unit_test.sv
`timescale 1ns/1ps
module split_load_unit_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [5:0] req_size = 6'd1;
  logic [3:0] req_tag = '0;
  logic [25:0] cache_rd_line;
  logic [511:0] cache_rd_data;
  logic rsp_valid;
  logic [1:0] rsp_kind;
  logic [3:0] rsp_tag;
  logic [255:0] rsp_data;
  logic [15:0] stall_count;

  int n_chk = 0, n_fail = 0, exp_stall = 0;

  always #2.5 clk = ~clk;

  split_load_unit uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr), .req_size(req_size),
    .req_tag(req_tag), .cache_rd_line(cache_rd_line), .cache_rd_data(cache_rd_data),
    .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_tag(rsp_tag), .rsp_data(rsp_data),
    .stall_count(stall_count)
  );

  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    logic [31:0] h;
    h = a * 32'h9E3779B1;
    return h[23:16] ^ a[7:0];
  endfunction

  function automatic logic [255:0] exp_load(input logic [31:0] a, input int sz);
    logic [255:0] r;
    r = '0;
    for (int i = 0; i < sz; i++) r[i*8 +: 8] = mem_byte(a + 32'(i));
    return r;
  endfunction

  function automatic bit crosses(input logic [31:0] a, input int sz);
    return int'(a[5:0]) + sz > 64;
  endfunction

  always_comb begin
    for (int b = 0; b < 64; b++) cache_rd_data[b*8 +: 8] = mem_byte({cache_rd_line, 6'(b)});
  end

  task automatic check(input bit ok, input string req, input logic [255:0] act,
                       input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic dispatch(input logic [31:0] a, input int sz, input int tg,
                          output logic [1:0] k, output logic [255:0] d,
                          output logic [25:0] ln);
    req_valid = 1'b1; req_addr = a; req_size = 6'(sz); req_tag = 4'(tg);
    #1 ln = cache_rd_line;
    @(posedge clk); #1;
    k = rsp_kind; d = rsp_data;
    check(rsp_valid && rsp_tag == 4'(tg), "R8 response and tag", 256'(rsp_tag), 256'(tg));
    req_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic full_load(input logic [31:0] a, input int sz, input int tg);
    logic [1:0] k; logic [255:0] d; logic [25:0] ln;
    dispatch(a, sz, tg, k, d, ln);
    check(ln == a[31:6], "R2/R3 first line address", 256'(ln), 256'(a[31:6]));
    if (!crosses(a, sz)) begin
      check(k == 2'b00 && d == exp_load(a, sz), "R2 single-line load", d, exp_load(a, sz));
    end else begin
      check(k == 2'b01 && d == '0, "R3 first dispatch asks again", 256'(k), 256'h1);
      dispatch(a, sz, tg, k, d, ln);
      check(ln == a[31:6] + 26'd1, "R4 next line address", 256'(ln), 256'(a[31:6] + 26'd1));
      check(k == 2'b00 && d == exp_load(a, sz), "R4 merged result", d, exp_load(a, sz));
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [1:0] k; logic [255:0] d; logic [25:0] ln;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    check(!rsp_valid && stall_count == 0, "R1 reset state", 256'(stall_count), 256'h0);
    rst = 1'b0;
    @(negedge clk);
    check(!rsp_valid, "R8 idle gives no response", 256'(rsp_valid), 256'h0);

    // R2 and R9: boundary fits, full size, single byte
    full_load(32'h0000_1000, 32, 1);
    full_load(32'h0000_1020, 32, 2);
    full_load(32'h0000_103F, 1, 3);
    // R3 / R4: smallest and largest crossings
    full_load(32'h0000_203F, 2, 4);
    full_load(32'h0000_2021, 32, 5);
    full_load(32'hFFFF_FFF0, 32, 6);

    // R6 / R5: fill both slots, refuse a third, free one, retry
    dispatch(32'h0000_3030, 20, 7, k, d, ln);
    check(k == 2'b01, "R1 first slot free after reset", 256'(k), 256'h1);
    dispatch(32'h0000_4038, 16, 8, k, d, ln);
    check(k == 2'b01, "R1 second slot free after reset", 256'(k), 256'h1);
    dispatch(32'h0000_5039, 30, 9, k, d, ln);
    exp_stall++;
    check(k == 2'b10 && d == '0, "R6 refused when pool full", 256'(k), 256'h2);
    check(stall_count == 16'(exp_stall), "R6 counter step", 256'(stall_count), 256'(exp_stall));
    dispatch(32'h0000_3030, 20, 7, k, d, ln);
    check(k == 2'b00 && d == exp_load(32'h0000_3030, 20), "R6 parked data kept",
          d, exp_load(32'h0000_3030, 20));
    full_load(32'h0000_5039, 30, 9);
    check(stall_count == 16'(exp_stall), "R5 no refusal after release",
          256'(stall_count), 256'(exp_stall));
    dispatch(32'h0000_4038, 16, 8, k, d, ln);
    check(k == 2'b00 && d == exp_load(32'h0000_4038, 16), "R4 older parked load",
          d, exp_load(32'h0000_4038, 16));

    // constrained random
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a; int sz;
      a = $urandom();
      sz = 1 + int'($urandom() % 32);
      if ($urandom() % 2 == 0) a[5:0] = 6'(63 - int'($urandom() % 32));
      full_load(a, sz, n % 16);
    end

    // R7: hold a refused dispatch until the counter saturates
    dispatch(32'h0000_6030, 32, 10, k, d, ln);
    dispatch(32'h0000_7030, 32, 11, k, d, ln);
    req_valid = 1'b1; req_addr = 32'h0000_8030; req_size = 6'd32; req_tag = 4'd12;
    repeat (70000) @(posedge clk);
    #1;
    check(stall_count == 16'hFFFF, "R7 counter saturates", 256'(stall_count), 256'hFFFF);
    check(rsp_kind == 2'b10, "R6 still refused", 256'(rsp_kind), 256'h2);
    req_valid = 1'b0;
    @(negedge clk);
    dispatch(32'h0000_6030, 32, 10, k, d, ln);
    check(k == 2'b00 && d == exp_load(32'h0000_6030, 32), "R6 parked data survives refusals",
          d, exp_load(32'h0000_6030, 32));
    check(stall_count == 16'hFFFF, "R7 counter holds", 256'(stall_count), 256'hFFFF);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule